// File: doc/BRIEF.md
# Digitally Trimmed 100 Hz Time-Base Divider

This block turns a 32768 Hz oscillator clock enable into a 100 Hz time-base tick and a 1 Hz tick. It applies accuracy correction in the digital divider and leaves the oscillator alone. Time is split into fixed correction windows of 1,015,808 oscillator cycles, which is 31 seconds. At the start of each window a small state machine removes a software-chosen number of oscillator cycles, from 0 to 255, from the divider input. Each removed cycle slows the time base by about 0.984 ppm, so the full code of 255 corrects about 251 ppm of fast crystal error.

After the gate, a divide-by-32 stage produces a 1024 Hz enable. A fractional stage turns that enable into the 100 Hz tick by alternating divide-by-10 and divide-by-11 periods. A final modulo-100 counter produces the 1 Hz tick. In frequency-tuning mode, a calibration output carries a 100 Hz waveform that is high for roughly 20% of each period, so the raw rate can be measured and the trim code worked out.

The gating state machine has three states. W_LOAD waits for the first oscillator cycle of a window and samples the trim code there. A non-zero code suppresses that cycle and moves to W_TRIM when more cycles remain, or to W_FREE otherwise. A zero code moves straight to W_FREE. W_TRIM suppresses one cycle per oscillator enable and moves to W_FREE after the last one. W_FREE passes every cycle and returns to W_LOAD after the window's final cycle.

Top module: `trim_divchain`

## Requirements
- R1: While rst_n is low, tick_100hz, tick_1hz and cal_out are 0. The first osc_en after reset is cycle 0 of a correction window.
- R2: A correction window is WIN_CYC osc_en cycles long. The default is 1,015,808. Windows follow each other with no gap.
- R3: In each window, the first T osc_en cycles do not reach the divider. T is the trim code, from 0 to 255. Every later cycle in the window reaches the divider.
- R4: Count only the osc_en cycles that reach the divider, and number the ticks from 1. The n-th 100 Hz tick follows the passed cycle number 32*(10*n + floor(6*n/25)). With a trim code of 0, no cycle is removed.
- R5: While trim_dis is 1, no cycle is removed, whatever the trim code.
- R6: The trim code is sampled only on cycle 0 of a window. A change later in the window takes effect from the next window.
- R7: tick_1hz is 1 on every 100th tick_100hz pulse, and only in a cycle where tick_100hz is also 1.
- R8: While tune_mode is 1, cal_out is 1 for the first two 1024 Hz periods of each 100 Hz period, and 0 for the rest of the period. While tune_mode is 0, cal_out stays 0.
- R9: All outputs are registered. A tick caused by the osc_en of clock edge k is visible from edge k+1 for one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32768 Hz oscillator rate |
| trim_val | input | 8 | Number of cycles to remove per window |
| trim_dis | input | 1 | Test input that blocks all cycle removal |
| tune_mode | input | 1 | Enables the calibration waveform |
| tick_100hz | output | 1 | 100 Hz time-base tick, one clock wide |
| tick_1hz | output | 1 | 1 Hz tick, one clock wide |
| cal_out | output | 1 | 100 Hz calibration waveform, about 20% duty |

## Verification
The bench compares the exact clock cycle of every 100 Hz tick with a model built from the window and gating rules. The corner cases it goes after are these:

- A trim code of 1. A design with an off-by-one in the removal count would show a tick slip of one cycle.
- A trim code of 255. A design that wraps the remaining-count would remove zero or 256 cycles.
- A code that changes in the middle of a window. A design that reads the code continuously would shift the ticks in window 0.
- The test disable input. A design that ignored it would delay every tick.

A 32768-cycle run with tuning mode on checks two more things. The 1 Hz tick must land on the 100th tick. The calibration high time must total exactly 64 passed cycles per 100 Hz period. A wrong fractional sequence would miss both.

// File: rtl/trim_divchain_pkg.sv
package trim_divchain_pkg;

    typedef enum logic [1:0] {
        W_LOAD = 2'd0,
        W_TRIM = 2'd1,
        W_FREE = 2'd2
    } win_state_e;

    localparam int unsigned PRE_DIV   = 32;
    localparam int unsigned FRAC_BASE = 10;
    localparam int unsigned FRAC_LONG = 6;
    localparam int unsigned FRAC_SPAN = 25;
    localparam int unsigned CAL_HEAD  = 2;
    localparam int unsigned SEC_TICKS = 100;

endpackage

// File: rtl/trim_gate_fsm.sv
module trim_gate_fsm
    import trim_divchain_pkg::*;
#(
    parameter int unsigned WIN_CYC = 1015808,
    parameter int unsigned TRIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              trim_dis,
    output logic              pass_en
);
    localparam int unsigned WCW = $clog2(WIN_CYC);
    localparam logic [WCW-1:0] WLAST = WCW'(WIN_CYC - 1);

    win_state_e        state_q, state_d;
    logic [TRIM_W-1:0] rem_q, rem_d;
    logic [WCW-1:0]    wcnt_q;
    logic              sup;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        sup     = 1'b0;
        unique case (state_q)
            W_LOAD: begin
                if (osc_en) begin
                    if (trim_val != '0) begin
                        sup     = 1'b1;
                        rem_d   = trim_val - TRIM_W'(1);
                        state_d = (trim_val > TRIM_W'(1)) ? W_TRIM : W_FREE;
                    end else begin
                        rem_d   = '0;
                        state_d = W_FREE;
                    end
                end
            end
            W_TRIM: begin
                if (osc_en) begin
                    sup   = 1'b1;
                    rem_d = rem_q - TRIM_W'(1);
                    if (rem_q == TRIM_W'(1)) state_d = W_FREE;
                end
            end
            W_FREE: begin
                if (osc_en && wcnt_q == WLAST) state_d = W_LOAD;
            end
            default: state_d = W_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_LOAD;
            rem_q   <= '0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            if (osc_en) wcnt_q <= (wcnt_q == WLAST) ? '0 : wcnt_q + WCW'(1);
        end
    end

    always_comb begin
        pass_en = osc_en && (!sup || trim_dis);
    end

    // R2
    window_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && wcnt_q == WLAST) |=> (state_q == W_LOAD));

    // R6
    load_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_LOAD) |-> (wcnt_q == '0));

    // R3
    free_no_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_FREE) |-> (rem_q == '0));

endmodule

// File: rtl/pre_div.sv
module pre_div #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_out
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] CLAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (en_in) cnt_q <= (cnt_q == CLAST) ? '0 : cnt_q + CW'(1);
    end

    assign en_out = en_in && (cnt_q == CLAST);

    // R4
    pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_out |=> (cnt_q == '0));

endmodule

// File: rtl/frac_div.sv
module frac_div #(
    parameter int unsigned BASE = 10,
    parameter int unsigned LONG = 6,
    parameter int unsigned SPAN = 25,
    parameter int unsigned HEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic tick,
    output logic head
);
    localparam int unsigned AW = $clog2(SPAN);
    localparam int unsigned FW = $clog2(BASE + 1);

    logic [AW-1:0] acc_q;
    logic [FW-1:0] fcnt_q;
    logic          long_per;
    logic [FW-1:0] lim;

    assign long_per = (32'(acc_q) >= SPAN - LONG);
    assign lim      = long_per ? FW'(BASE) : FW'(BASE - 1);
    assign tick     = en_in && (fcnt_q == lim);
    assign head     = (32'(fcnt_q) < HEAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fcnt_q <= '0;
        end else if (en_in) begin
            if (tick) begin
                fcnt_q <= '0;
                acc_q  <= long_per ? AW'(32'(acc_q) + LONG - SPAN)
                                   : AW'(32'(acc_q) + LONG);
            end else begin
                fcnt_q <= fcnt_q + FW'(1);
            end
        end
    end

    // R4
    frac_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (fcnt_q == '0));

    // R4
    frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fcnt_q) <= BASE);

endmodule

// File: rtl/sec_div.sv
module sec_div #(
    parameter int unsigned TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_out
);
    localparam int unsigned CW = $clog2(TICKS);
    localparam logic [CW-1:0] CLAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (en_in) cnt_q <= (cnt_q == CLAST) ? '0 : cnt_q + CW'(1);
    end

    assign en_out = en_in && (cnt_q == CLAST);

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_out |=> (cnt_q == '0));

endmodule

// File: rtl/trim_divchain.sv
module trim_divchain
    import trim_divchain_pkg::*;
#(
    parameter int unsigned WIN_CYC = 1015808,
    parameter int unsigned TRIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              trim_dis,
    input  logic              tune_mode,
    output logic              tick_100hz,
    output logic              tick_1hz,
    output logic              cal_out
);
    logic pass_en, e1024, t100, t1, head;

    trim_gate_fsm #(.WIN_CYC(WIN_CYC), .TRIM_W(TRIM_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .trim_val(trim_val), .trim_dis(trim_dis), .pass_en(pass_en)
    );

    pre_div #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .en_in(pass_en), .en_out(e1024)
    );

    frac_div #(.BASE(FRAC_BASE), .LONG(FRAC_LONG), .SPAN(FRAC_SPAN),
               .HEAD(CAL_HEAD)) u_frac (
        .clk(clk), .rst_n(rst_n), .en_in(e1024), .tick(t100), .head(head)
    );

    sec_div #(.TICKS(SEC_TICKS)) u_sec (
        .clk(clk), .rst_n(rst_n), .en_in(t100), .en_out(t1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_100hz <= 1'b0;
            tick_1hz   <= 1'b0;
            cal_out    <= 1'b0;
        end else begin
            tick_100hz <= t100;
            tick_1hz   <= t1;
            cal_out    <= tune_mode && head;
        end
    end

    // R7
    sec_in_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> tick_100hz);

    // R8
    cal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tune_mode |=> !cal_out);

endmodule

// File: tb/tb_trim_divchain.sv
module tb_trim_divchain;
    localparam int W = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic [7:0] trim_val = '0;
    logic       trim_dis = 1'b0;
    logic       tune_mode = 1'b0;
    logic       tick_100hz, tick_1hz, cal_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int mism, nticks, n1hz, cal_hi, exp_n;

    always #5 clk = ~clk;

    trim_divchain #(.WIN_CYC(W), .TRIM_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_val(trim_val),
        .trim_dis(trim_dis), .tune_mode(tune_mode),
        .tick_100hz(tick_100hz), .tick_1hz(tick_1hz), .cal_out(cal_out)
    );

    // {trim before cycle 500, trim after, trim_dis, removed in window 0, removed later}
    localparam int VEC [8][5] = '{
        '{  0,   0, 0,   0,   0},
        '{  5,   5, 0,   5,   5},
        '{  1,   1, 0,   1,   1},
        '{255, 255, 0, 255, 255},
        '{200, 200, 1,   0,   0},
        '{ 10,  40, 0,  10,  40},
        '{  0,  77, 0,   0,  77},
        '{128,   3, 0, 128,   3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run_vec(input int a, input int b, input int dis,
                           input int sa, input int sb, input int tune,
                           input int ncyc);
        int pc, n;
        bit et, es;
        rst_n = 1'b0; osc_en = 1'b0;
        trim_val = 8'(a); trim_dis = dis[0]; tune_mode = tune[0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1; osc_en = 1'b1;
        pc = 0; n = 0; mism = 0; nticks = 0; n1hz = 0; cal_hi = 0;
        for (int i = 0; i < ncyc; i++) begin
            int pos, tw;
            if (i == 500) trim_val = 8'(b);
            pos = i % W;
            tw = (i / W == 0) ? sa : sb;
            et = 0; es = 0;
            if (pos >= tw) begin
                pc++;
                if (pc == 32 * (10 * (n + 1) + (6 * (n + 1)) / 25)) begin
                    n++;
                    et = 1;
                    es = (n % 100 == 0);
                end
            end
            @(negedge clk);
            if (tick_100hz !== et || tick_1hz !== es) mism++;
            if (tick_100hz) nticks++;
            if (tick_1hz) n1hz++;
            if (cal_out) cal_hi++;
        end
        exp_n = n;
        osc_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle while reset is held
        repeat (3) @(negedge clk);
        chk(tick_100hz == 0 && tick_1hz == 0 && cal_out == 0, "R1 reset outputs",
            int'({tick_100hz, tick_1hz, cal_out}), 0);

        // Table walk: exact tick timing over three windows
        for (int v = 0; v < 8; v++) begin
            string tag;
            if (VEC[v][2] != 0)              tag = "R5";
            else if (VEC[v][0] != VEC[v][1]) tag = "R6";
            else if (VEC[v][0] == 0)         tag = "R4";
            else                             tag = "R3";
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 3 * W);
            chk(mism == 0, $sformatf("%s R2/R9 tick timing vec%0d mismatches", tag, v), mism, 0);
            chk(nticks == exp_n, $sformatf("%s tick count vec%0d", tag, v), nticks, exp_n);
            chk(cal_hi == 0, $sformatf("R8 cal idle with tune off vec%0d", v), cal_hi, 0);
        end

        // Directed: 1 Hz tick and calibration duty over 100 periods
        run_vec(0, 0, 0, 0, 0, 1, 32768);
        chk(mism == 0, "R7 tick and 1Hz timing mismatches", mism, 0);
        chk(n1hz == 1, "R7 one second tick count", n1hz, 1);
        chk(nticks == 100, "R4 hundred ticks per 32768 cycles", nticks, 100);
        chk(cal_hi == 6400, "R8 calibration high cycles", cal_hi, 6400);

        // Directed: disable with full-scale trim over long run
        run_vec(255, 255, 1, 0, 0, 0, 32768);
        chk(n1hz == 1 && mism == 0, "R5 full-scale code blocked", mism, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule